// File: doc/BRIEF.md
# Linear DDR Memory Test Sequencer

This block runs a self-contained write-then-readback test through the user port of a simple DDR controller. After a start pulse it writes an incrementing pattern over a linear word range, one burst per command, with every word holding its own linear address. It then reads the same range back in the same ascending order and compares each returned word against a separate expected-value counter. Because read data can come back any number of cycles after its command is accepted, the comparison follows the order in which words arrive, not the command timing.

A flat linear address is split into column, row and bank fields. The column field takes the least significant bits, so a linear sweep stays inside one open row until the column range is used up. The row and bank fields take the upper bits, in an order chosen by a parameter. Every command starts on a burst-aligned column, so the memory's internal column increment never wraps inside a burst. At the end of the run the block reports pass or fail, the first address that mismatched, and a saturating count of mismatches. It holds these results until the next start.

Top module: `memtest_top`

## Requirements
- R1: After reset `busy`, `done`, `pass`, `cmdValid` and `errCount` are 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. A `start` while busy has no effect: the command sequence carries on uninterrupted.
- R3: During the write phase `cmdWrite` is 1 and the commands cover linear addresses 0, BL, 2·BL, … up to TEST_WORDS−BL (BL = `BURST_LEN`, default 4; TEST_WORDS default 1024), each exactly once. Word i of `cmdWdata` (bits i·DATA_W upward) equals the low DATA_W bits of address+i.
- R4: A linear address A maps to `cmdCol` = A mod 2^COL_W, `cmdRow` = (A >> COL_W) mod 2^ROW_W and `cmdBank` = A >> (COL_W+ROW_W) (bank above row, the default; defaults COL_W=6, ROW_W=3, BANK_W=1).
- R5: Every issued `cmdCol` is a multiple of BL.
- R6: While `cmdValid` is high and `cmdReady` is low, the command's write flag, address fields and data stay unchanged.
- R7: The read phase starts only after the last write is accepted. It issues `cmdWrite`=0 commands over the same addresses in the same ascending order.
- R8: Returned words (`rdValid` high) are compared in arrival order against expected values 0,1,2,…, whatever the latency and gaps between them.
- R9: `firstFailAddr` holds the linear address of the first mismatching word. Later mismatches do not change it.
- R10: `errCount` increments on each mismatch and saturates at 2^ERR_W−1 (255 by default).
- R11: After the last expected word returns, `busy` falls and `done` rises in the same cycle. `pass` = `done` with `errCount`=0. Results are held until the next start, which clears `done`, `errCount` and `firstFailAddr`.
- R12: `rdValid` pulses outside the read phase are ignored and change neither `errCount`, `firstFailAddr` nor `pass`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| busy | output | 1 | Test running |
| done | output | 1 | Test finished, results valid |
| pass | output | 1 | Finished with no mismatch |
| cmdValid | output | 1 | Command request |
| cmdReady | input | 1 | Command acknowledge |
| cmdWrite | output | 1 | 1 = write burst, 0 = read burst |
| cmdBank | output | BANK_W | Bank field |
| cmdRow | output | ROW_W | Row field |
| cmdCol | output | COL_W | Column field (burst aligned) |
| cmdWdata | output | DATA_W·BURST_LEN | Burst write data, word 0 in the low bits |
| rdValid | input | 1 | Read data strobe |
| rdData | input | DATA_W | Read data word |
| firstFailAddr | output | COL_W+ROW_W+BANK_W | Linear address of first mismatch |
| errCount | output | ERR_W | Saturating mismatch count |

## Verification
The hardest case to reach from the ports is a read return that arrives late, or in a burst of back-to-back words, while read commands are still being issued. Add to that stray strobes in the write phase and a restart attempt in the middle of a run. The bench's memory model accepts commands with a random acknowledge and returns queued words with random gaps. It injects stray `rdValid` pulses during writes and while idle, and corrupts either a directed set of addresses, a pseudo-random set, or every word. The all-corrupt run drives the error counter past saturation.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD, ST_DRAIN} phase_t;

  typedef struct packed {
    logic clear;    // new run: zero counters and results
    logic advAddr;  // command accepted, step to next burst
    logic rstAddr;  // last command of a phase accepted
    logic cmpEn;    // a read word is to be checked
  } dpCtl_t;
endpackage

// File: rtl/memtest_addr_map.sv
module memtest_addr_map #(
  parameter int COL_W = 6,
  parameter int ROW_W = 3,
  parameter int BANK_W = 1,
  parameter bit BANK_ON_TOP = 1'b1,
  localparam int LIN_W = COL_W + ROW_W + BANK_W
) (
  input  logic [LIN_W-1:0]  linAddr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign col = linAddr[COL_W-1:0];
  generate
    if (BANK_ON_TOP) begin : g_bank_high
      assign row  = linAddr[COL_W +: ROW_W];
      assign bank = linAddr[COL_W+ROW_W +: BANK_W];
    end else begin : g_row_high
      assign bank = linAddr[COL_W +: BANK_W];
      assign row  = linAddr[COL_W+BANK_W +: ROW_W];
    end
  endgenerate
endmodule

// File: rtl/memtest_ctrl.sv
module memtest_ctrl
  import memtest_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cmdReady,
  input  logic   rdValid,
  input  logic   lastCmd,
  input  logic   lastWord,
  output logic   busy,
  output logic   done,
  output logic   cmdValid,
  output logic   cmdWrite,
  output dpCtl_t ctl
);
  phase_t state, stateNext;
  logic   doneQ;
  logic   accept;

  assign cmdValid = (state == ST_WR) || (state == ST_RD);
  assign cmdWrite = (state == ST_WR);
  assign accept   = cmdValid && cmdReady;
  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;

  always_comb begin
    ctl.clear   = start && (state == ST_IDLE);
    ctl.advAddr = accept && !lastCmd;
    ctl.rstAddr = accept && lastCmd;
    ctl.cmpEn   = rdValid && ((state == ST_RD) || (state == ST_DRAIN));
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_WR;
      ST_WR:    if (accept && lastCmd) stateNext = ST_RD;
      ST_RD:    if (accept && lastCmd) stateNext = ST_DRAIN;
      ST_DRAIN: if (lastWord) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.clear) doneQ <= 1'b0;
      else if (state == ST_DRAIN && lastWord) doneQ <= 1'b1;
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  p_hold_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdWrite)));
  p_rd_after_wr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !cmdReady) |=> cmdWrite);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/memtest_dpath.sv
module memtest_dpath
  import memtest_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W = 6,
  parameter int ROW_W = 3,
  parameter int BANK_W = 1,
  parameter int BURST_LEN = 4,
  parameter int TEST_WORDS = 1024,
  parameter int ERR_W = 8,
  parameter bit BANK_ON_TOP = 1'b1,
  localparam int LIN_W = COL_W + ROW_W + BANK_W,
  localparam int CNT_W = LIN_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtl_t                      ctl,
  input  logic [DATA_W-1:0]           rdData,
  output logic                        lastCmd,
  output logic                        lastWord,
  output logic [BANK_W-1:0]           cmdBank,
  output logic [ROW_W-1:0]            cmdRow,
  output logic [COL_W-1:0]            cmdCol,
  output logic [DATA_W*BURST_LEN-1:0] cmdWdata,
  output logic [LIN_W-1:0]            firstFailAddr,
  output logic [ERR_W-1:0]            errCount
);
  localparam logic [LIN_W-1:0] LAST_BURST = LIN_W'(TEST_WORDS - BURST_LEN);
  localparam logic [CNT_W-1:0] LAST_EXP   = CNT_W'(TEST_WORDS - 1);
  localparam logic [ERR_W-1:0] ERR_MAX    = {ERR_W{1'b1}};
  localparam logic [LIN_W-1:0] BL_STEP    = LIN_W'(BURST_LEN);

  logic [LIN_W-1:0] linAddr;
  logic [CNT_W-1:0] expCnt;
  logic             mismatch;

  assign lastCmd  = (linAddr == LAST_BURST);
  assign lastWord = ctl.cmpEn && (expCnt == LAST_EXP);
  assign mismatch = ctl.cmpEn && (rdData != DATA_W'(expCnt));

  memtest_addr_map #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .BANK_ON_TOP(BANK_ON_TOP)
  ) u_map (
    .linAddr(linAddr), .bank(cmdBank), .row(cmdRow), .col(cmdCol)
  );

  generate
    for (genvar w = 0; w < BURST_LEN; w++) begin : g_wdata
      assign cmdWdata[w*DATA_W +: DATA_W] = DATA_W'(linAddr + LIN_W'(w));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linAddr       <= '0;
      expCnt        <= '0;
      firstFailAddr <= '0;
      errCount      <= '0;
    end else if (ctl.clear) begin
      linAddr       <= '0;
      expCnt        <= '0;
      firstFailAddr <= '0;
      errCount      <= '0;
    end else begin
      if (ctl.rstAddr)      linAddr <= '0;
      else if (ctl.advAddr) linAddr <= linAddr + BL_STEP;
      if (ctl.cmpEn) expCnt <= expCnt + 1'b1;
      if (mismatch) begin
        if (errCount == '0) firstFailAddr <= expCnt[LIN_W-1:0];
        if (errCount != ERR_MAX) errCount <= errCount + 1'b1;
      end
    end
  end

  p_col_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> ((linAddr % BL_STEP) == '0));
  p_first_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((errCount != '0) && !ctl.clear) |=> $stable(firstFailAddr));
  p_err_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((errCount == ERR_MAX) && !ctl.clear) |=> (errCount == ERR_MAX));
  p_no_cmp_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cmpEn && !ctl.clear) |=> ($stable(errCount) && $stable(expCnt)));
endmodule

// File: rtl/memtest_top.sv
module memtest_top
  import memtest_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W = 6,
  parameter int ROW_W = 3,
  parameter int BANK_W = 1,
  parameter int BURST_LEN = 4,
  parameter int TEST_WORDS = 1024,
  parameter int ERR_W = 8,
  parameter bit BANK_ON_TOP = 1'b1,
  localparam int LIN_W = COL_W + ROW_W + BANK_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  output logic                        busy,
  output logic                        done,
  output logic                        pass,
  output logic                        cmdValid,
  input  logic                        cmdReady,
  output logic                        cmdWrite,
  output logic [BANK_W-1:0]           cmdBank,
  output logic [ROW_W-1:0]            cmdRow,
  output logic [COL_W-1:0]            cmdCol,
  output logic [DATA_W*BURST_LEN-1:0] cmdWdata,
  input  logic                        rdValid,
  input  logic [DATA_W-1:0]           rdData,
  output logic [LIN_W-1:0]            firstFailAddr,
  output logic [ERR_W-1:0]            errCount
);
  dpCtl_t ctl;
  logic   lastCmd, lastWord;

  memtest_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdReady(cmdReady),
    .rdValid(rdValid), .lastCmd(lastCmd), .lastWord(lastWord),
    .busy(busy), .done(done), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .ctl(ctl)
  );

  memtest_dpath #(
    .DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W),
    .BURST_LEN(BURST_LEN), .TEST_WORDS(TEST_WORDS), .ERR_W(ERR_W),
    .BANK_ON_TOP(BANK_ON_TOP)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(rdData),
    .lastCmd(lastCmd), .lastWord(lastWord),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdWdata(cmdWdata),
    .firstFailAddr(firstFailAddr), .errCount(errCount)
  );

  assign pass = done && (errCount == '0);
endmodule

// File: tb/memtest_top_tb.sv
module memtest_top_tb;
  localparam int BL = 4;
  localparam int WORDS = 1024;
  localparam int NCMD = WORDS / BL;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic busy, done, pass, cmdValid, cmdReady = 1'b0, cmdWrite;
  logic [0:0] cmdBank;
  logic [2:0] cmdRow;
  logic [5:0] cmdCol;
  logic [63:0] cmdWdata;
  logic rdValid = 1'b0;
  logic [15:0] rdData = '0;
  logic [9:0] firstFailAddr;
  logic [7:0] errCount;

  memtest_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .pass(pass), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .cmdCol(cmdCol), .cmdWdata(cmdWdata), .rdValid(rdValid),
    .rdData(rdData), .firstFailAddr(firstFailAddr), .errCount(errCount)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int writesSeen, readsSeen, readyPct, corruptMode, randKey;
  bit respOn = 0, strayWr = 0, strayIdle = 0, prevStall = 0;
  logic [75:0] savedCmd;
  logic [15:0] mem [WORDS];
  int rq [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit corruptAt(input int a);
    case (corruptMode)
      1: return (a == 37) || (a == 500) || (a == 900);
      2: return 1'b1;
      3: return ((a * 37 + randKey) % 97) == 0;
      default: return 1'b0;
    endcase
  endfunction

  // expected {bank,row,col} for linear address a (R4)
  function automatic logic [9:0] mapOf(input int a);
    return {1'(a / 512), 3'((a / 64) % 8), 6'(a % 64)};
  endfunction

  initial forever begin
    @(negedge clk);
    if (respOn) begin
      int lin;
      bit rdy;
      if (prevStall)
        check({cmdValid, cmdWrite, cmdBank, cmdRow, cmdCol, cmdWdata} == savedCmd, "R6 hold",
              64'({cmdBank, cmdRow, cmdCol}), 64'(savedCmd[73:64]));
      rdy = ($urandom_range(99) < readyPct);
      cmdReady = rdy;
      lin = int'(cmdBank) * 512 + int'(cmdRow) * 64 + int'(cmdCol);
      if (cmdValid && rdy) begin
        check((cmdCol % BL) == 0, "R5 align", 64'(cmdCol), 64'(0));
        if (cmdWrite) begin
          logic [63:0] expData;
          for (int i = 0; i < BL; i++) expData[i*16 +: 16] = 16'(writesSeen * BL + i);
          check({cmdBank, cmdRow, cmdCol} == mapOf(writesSeen * BL), "R3/R4 write addr",
                64'({cmdBank, cmdRow, cmdCol}), 64'(mapOf(writesSeen * BL)));
          check(cmdWdata == expData, "R3 write data", cmdWdata, expData);
          for (int i = 0; i < BL; i++) mem[lin + i] = cmdWdata[i*16 +: 16];
          writesSeen++;
        end else begin
          check(writesSeen == NCMD, "R7 read after writes", 64'(writesSeen), 64'(NCMD));
          check({cmdBank, cmdRow, cmdCol} == mapOf(readsSeen * BL), "R7/R4 read addr",
                64'({cmdBank, cmdRow, cmdCol}), 64'(mapOf(readsSeen * BL)));
          for (int i = 0; i < BL; i++) rq.push_back(lin + i);
          readsSeen++;
        end
      end
      prevStall = cmdValid && !rdy;
      savedCmd = {cmdValid, cmdWrite, cmdBank, cmdRow, cmdCol, cmdWdata};
      if (rq.size() > 0 && $urandom_range(99) < 60) begin
        int a;
        a = rq.pop_front();
        rdValid = 1'b1;
        rdData = mem[a] ^ (corruptAt(a) ? 16'h5A5A : 16'h0);
      end else if (strayWr && writesSeen < NCMD && $urandom_range(99) < 30) begin
        rdValid = 1'b1;  // R12 stray strobe during the write phase
        rdData = 16'hDEAD;
      end else begin
        rdValid = 1'b0;
      end
    end else begin
      cmdReady = 1'b0;
      prevStall = 0;
      rdValid = strayIdle;
      rdData = 16'hBEEF;
    end
  end

  task automatic runTest(input int mode, input int pct, input bit stray, input bit midStart);
    int cyc;
    corruptMode = mode; readyPct = pct; strayWr = stray;
    writesSeen = 0; readsSeen = 0; rq.delete();
    for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
    respOn = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'(1));
    check(done == 1'b0, "R11 done cleared by start", 64'(done), 64'(0));
    cyc = 0;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 150) start = 1'b1;  // R2 ignored while busy
      if (midStart && cyc == 151) start = 1'b0;
    end
    if (cyc >= 30000) check(1'b0, "watchdog", 64'(cyc), 64'(0));
    respOn = 0;
    check(busy == 1'b0, "R11 busy low at end", 64'(busy), 64'(0));
    check(writesSeen == NCMD, "R3 write count", 64'(writesSeen), 64'(NCMD));
    check(readsSeen == NCMD, "R7 read count", 64'(readsSeen), 64'(NCMD));
  endtask

  task automatic expectResult(input string tag);
    int cnt, first;
    cnt = 0; first = 0;
    for (int a = WORDS - 1; a >= 0; a--) if (corruptAt(a)) begin cnt++; first = a; end
    if (cnt > 255) cnt = 255;
    check(errCount == 8'(cnt), {tag, " R8/R10 errCount"}, 64'(errCount), 64'(cnt));
    check(firstFailAddr == 10'(first), {tag, " R9 firstFailAddr"}, 64'(firstFailAddr), 64'(first));
    check(pass == (cnt == 0), {tag, " R11 pass"}, 64'(pass), 64'(cnt == 0));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check({busy, done, pass, cmdValid} == 4'b0 && errCount == 0, "R1 reset",
          64'({busy, done, pass, cmdValid, errCount}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && cmdValid == 1'b0, "R1 idle", 64'({busy, cmdValid}), 64'(0));

    runTest(0, 100, 1'b1, 1'b1); expectResult("clean");
    strayIdle = 1;                                   // R12 strobes while idle
    repeat (20) @(negedge clk);
    strayIdle = 0;
    @(negedge clk);
    expectResult("idle stray");
    check(done == 1'b1, "R11 done held", 64'(done), 64'(1));

    runTest(1, 70, 1'b0, 1'b0); expectResult("directed");
    runTest(2, 50, 1'b1, 1'b0); expectResult("all corrupt");
    randKey = int'($urandom_range(96));
    runTest(3, 85, 1'b0, 1'b1); expectResult("random set");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule